// File: doc/BRIEF.md
# Multi-Master Read Prefetch Buffer

This block sits between a memory-mapped read port and a serial memory read engine. One shared storage array of 128 words of 64 bits is carved into four prefetch partitions, each owned by one requesting master through a configured master ID. A read that falls inside the words already held by the requester's partition is answered from storage on the next cycle without touching the memory. A read that misses empties the partition and asks the memory engine for a burst that starts at the missing address, aligned down to 8 bytes. The burst is as long as the partition. The first returned word answers the read, and the rest of the burst fills the partition in the background.

Prefetch runs only when the global enable and the enable of the selected partition are both set. Without it, each read becomes a one-word memory access whose data is never kept. If the owner of the partition that is still filling misses again, the running burst is cancelled through an abort/acknowledge handshake before the new burst is requested. A miss by a different master waits until the running burst has finished.

Top module: `rd_prefetch_buf`

## Requirements
- R1: The partitions occupy disjoint ranges of the storage array, laid out back to back in index order starting at word 0. Partition i starts at the sum of the effective sizes of partitions 0..i-1. Data held for one master is never overwritten by a fill for another master.
- R2: A request ID equal to a partition's configured ID selects that partition, and the lowest index wins when several match. An ID that matches no partition selects partition 3, the shared one.
- R3: A read is handled as a prefetch only when `cfg_pf_en` is 1, bit `b` of `cfg_buf_pf_en` is 1 for the selected partition `b`, and that partition's effective size is non-zero.
- R4: A prefetch miss issues exactly one memory request. Its byte address is the read address with bits [2:0] cleared, and its length in 64-bit words equals the partition's effective size.
- R5: On a miss, the first returned word is delivered on `rs_data` with `rs_valid` high in the cycle right after the cycle in which that word arrived.
- R6: A read inside the words held by the selected partition has `rs_valid` high in the cycle right after acceptance and produces no memory request.
- R7: When prefetch is off for the selected partition, a read issues a request of length 1 and leaves that partition empty, so an identical repeated read issues another request.
- R8: A miss by the owner of the partition being filled raises `mem_abort` and holds it until `mem_abort_ack`. No request is issued while `mem_abort` is high. The new burst is requested afterwards, and the old contents are discarded.
- R9: A miss for another partition while a burst is running issues no abort. Its request is issued only after the running burst has delivered its last word.
- R10: Effective sizes are the configured sizes clamped in index order so that their sum never exceeds 128. Partition i gets at most 128 minus the sizes already granted to partitions 0..i-1.
- R11: During a background fill, words of that burst that have already arrived are served as hits. Words arriving on `mem_rd_valid` while an abort is pending are dropped.
- R12: After reset `rq_ready` is 1, and `rs_valid`, `mem_req_valid` and `mem_abort` are 0.
- R13: Once raised, `mem_req_valid` stays high with unchanged `mem_req_addr` and `mem_req_len` until the cycle in which `mem_req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pf_en | input | 1 | Global prefetch enable |
| cfg_buf_pf_en | input | NBUF | Per-partition prefetch enable |
| cfg_buf_size | input | NBUF x SZW | Requested partition sizes in 64-bit words |
| cfg_buf_mid | input | NBUF x IDW | Master ID owning each partition |
| rq_valid | input | 1 | Read request valid |
| rq_ready | output | 1 | Read request accepted when high together with rq_valid |
| rq_mid | input | IDW | Master ID of the request |
| rq_addr | input | AW | Byte address of the request |
| rs_valid | output | 1 | One-cycle response strobe |
| rs_data | output | DW | Response data |
| mem_req_valid | output | 1 | Memory burst request valid |
| mem_req_ready | input | 1 | Memory engine takes the request |
| mem_req_addr | output | AW | Burst start byte address, 8-byte aligned |
| mem_req_len | output | SZW | Burst length in 64-bit words |
| mem_rd_valid | input | 1 | Returned word valid |
| mem_rd_data | input | DW | Returned word |
| mem_abort | output | 1 | Cancel the running burst |
| mem_abort_ack | input | 1 | Engine has closed the cancelled burst |

## Verification
The bench builds the block with its defaults: four partitions, 128 words of 64 bits, 32-bit addresses and 4-bit master IDs. This puts the capacity clamp within reach with ordinary configurations such as 100+50+20+20, including a partition that is clamped to zero. The bench's memory model can slow its word rate to one word every four cycles. That keeps a 16-word fill open long enough to land hits, same-master aborts and other-master waits in the middle of a burst. It can also delay its request acceptance, which exercises request stability.

// File: rtl/pfb_pkg.sv
`timescale 1ns/1ps
package pfb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LAUNCH,
    ST_REQ,
    ST_FIRST,
    ST_FILL,
    ST_WAITF,
    ST_ABORT
  } pfb_state_t;
endpackage

// File: rtl/pfb_part_map.sv
`timescale 1ns/1ps
module pfb_part_map #(
  parameter int NBUF  = 4,
  parameter int DEPTH = 128,
  parameter int SZW   = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NBUF-1:0][SZW-1:0]  cfg_size,
  output logic [NBUF-1:0][SZW-1:0]  eff_size,
  output logic [NBUF-1:0][SZW-1:0]  part_base
);
  logic [SZW-1:0] used;

  // Walk partitions in index order, granting each what is left.
  always_comb begin
    logic [SZW-1:0] run;
    logic [SZW-1:0] room;
    run = '0;
    for (int i = 0; i < NBUF; i++) begin
      room         = SZW'(DEPTH) - run;
      part_base[i] = run;
      eff_size[i]  = (cfg_size[i] > room) ? room : cfg_size[i];
      run          = run + eff_size[i];
    end
    used = run;
  end

  assert_total_fits_R10: assert property (@(posedge clk) disable iff (rst)
    used <= SZW'(DEPTH));

  for (genvar gi = 0; gi < NBUF; gi++) begin : g_chk
    assert_only_shrinks_R10: assert property (@(posedge clk) disable iff (rst)
      eff_size[gi] <= cfg_size[gi]);
  end
endmodule

// File: rtl/pfb_store.sv
`timescale 1ns/1ps
module pfb_store #(
  parameter int DEPTH = 128,
  parameter int DW    = 64,
  parameter int IDXW  = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [IDXW-1:0] waddr,
  input  logic [DW-1:0]   wdata,
  input  logic            re,
  input  logic [IDXW-1:0] raddr,
  output logic [DW-1:0]   rdata
);
  logic [DW-1:0] mem [DEPTH];

  // Simple dual-port array with a registered read port.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pfb_lookup.sv
`timescale 1ns/1ps
module pfb_lookup #(
  parameter int NBUF = 4,
  parameter int IDW  = 4,
  parameter int WAW  = 29,
  parameter int SZW  = 8,
  parameter int IDXW = 7,
  parameter int BIW  = $clog2(NBUF)
) (
  input  logic [IDW-1:0]            rq_mid,
  input  logic [WAW-1:0]            rq_waddr,
  input  logic [NBUF-1:0][IDW-1:0]  buf_mid,
  input  logic [NBUF-1:0][WAW-1:0]  tag_base,
  input  logic [NBUF-1:0][SZW-1:0]  tag_cnt,
  input  logic [NBUF-1:0][SZW-1:0]  eff_size,
  input  logic [NBUF-1:0][SZW-1:0]  part_base,
  output logic [BIW-1:0]            sel,
  output logic                      hit,
  output logic [IDXW-1:0]           ram_idx
);
  logic [NBUF-1:0] match;
  logic [WAW-1:0]  off;

  for (genvar gi = 0; gi < NBUF; gi++) begin : g_match
    assign match[gi] = (buf_mid[gi] == rq_mid);
  end

  // Lowest matching index wins; no match falls to the last (shared) partition.
  always_comb begin
    sel = BIW'(NBUF - 1);
    for (int i = NBUF - 1; i >= 0; i--)
      if (match[i]) sel = BIW'(i);
  end

  assign off     = rq_waddr - tag_base[sel];
  assign hit     = (off < WAW'(tag_cnt[sel])) && (off < WAW'(eff_size[sel]));
  assign ram_idx = IDXW'(part_base[sel] + off[SZW-1:0]);
endmodule

// File: rtl/rd_prefetch_buf.sv
`timescale 1ns/1ps
module rd_prefetch_buf
  import pfb_pkg::*;
#(
  parameter int NBUF  = 4,
  parameter int DEPTH = 128,
  parameter int DW    = 64,
  parameter int AW    = 32,
  parameter int IDW   = 4,
  parameter int SZW   = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_pf_en,
  input  logic [NBUF-1:0]           cfg_buf_pf_en,
  input  logic [NBUF-1:0][SZW-1:0]  cfg_buf_size,
  input  logic [NBUF-1:0][IDW-1:0]  cfg_buf_mid,
  input  logic                      rq_valid,
  output logic                      rq_ready,
  input  logic [IDW-1:0]            rq_mid,
  input  logic [AW-1:0]             rq_addr,
  output logic                      rs_valid,
  output logic [DW-1:0]             rs_data,
  output logic                      mem_req_valid,
  input  logic                      mem_req_ready,
  output logic [AW-1:0]             mem_req_addr,
  output logic [SZW-1:0]            mem_req_len,
  input  logic                      mem_rd_valid,
  input  logic [DW-1:0]             mem_rd_data,
  output logic                      mem_abort,
  input  logic                      mem_abort_ack
);
  localparam int IDXW = $clog2(DEPTH);
  localparam int BIW  = $clog2(NBUF);
  localparam int BYW  = $clog2(DW / 8);
  localparam int WAW  = AW - BYW;

  pfb_state_t state;

  logic [NBUF-1:0][SZW-1:0] eff_size, part_base;
  logic [NBUF-1:0][WAW-1:0] tag_base;
  logic [NBUF-1:0][SZW-1:0] tag_cnt;

  // Running fill and the fill queued behind it.
  logic [BIW-1:0] f_buf,   nx_buf;
  logic [WAW-1:0] f_waddr, nx_waddr;
  logic [SZW-1:0] f_len,   nx_len;
  logic           f_keep,  nx_keep;
  logic [SZW-1:0] f_cnt;

  logic [WAW-1:0]  rq_waddr;
  logic [BIW-1:0]  sel;
  logic            lk_hit, keep_sel, hit, accept;
  logic [SZW-1:0]  len_sel;
  logic [IDXW-1:0] rd_idx;
  logic            st_we, st_re;
  logic [IDXW-1:0] st_waddr;
  logic [DW-1:0]   ram_q, byp;
  logic            rs_from_ram;
  logic            fill_beat, last_beat;
  logic            unused_lo;

  assign unused_lo = ^rq_addr[BYW-1:0];
  assign rq_waddr  = rq_addr[AW-1:BYW];

  pfb_part_map #(.NBUF(NBUF), .DEPTH(DEPTH), .SZW(SZW)) u_map (
    .clk(clk), .rst(rst), .cfg_size(cfg_buf_size),
    .eff_size(eff_size), .part_base(part_base));

  pfb_lookup #(.NBUF(NBUF), .IDW(IDW), .WAW(WAW), .SZW(SZW), .IDXW(IDXW), .BIW(BIW)) u_lk (
    .rq_mid(rq_mid), .rq_waddr(rq_waddr), .buf_mid(cfg_buf_mid),
    .tag_base(tag_base), .tag_cnt(tag_cnt), .eff_size(eff_size),
    .part_base(part_base), .sel(sel), .hit(lk_hit), .ram_idx(rd_idx));

  assign rq_ready  = (state == ST_IDLE) || (state == ST_FILL);
  assign accept    = rq_valid && rq_ready;
  assign keep_sel  = cfg_pf_en && cfg_buf_pf_en[sel] && (eff_size[sel] != '0);
  assign hit       = lk_hit && keep_sel;
  assign len_sel   = keep_sel ? eff_size[sel] : SZW'(1);

  assign fill_beat = mem_rd_valid && ((state == ST_FILL) || (state == ST_WAITF));
  assign last_beat = fill_beat && ((f_cnt + SZW'(1)) == f_len);

  assign st_we    = (state == ST_FIRST && mem_rd_valid && f_keep) || fill_beat;
  assign st_waddr = IDXW'(part_base[f_buf] + f_cnt);
  assign st_re    = accept && hit;

  pfb_store #(.DEPTH(DEPTH), .DW(DW), .IDXW(IDXW)) u_store (
    .clk(clk), .we(st_we), .waddr(st_waddr), .wdata(mem_rd_data),
    .re(st_re), .raddr(rd_idx), .rdata(ram_q));

  assign rs_data = rs_from_ram ? ram_q : byp;

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      rs_valid      <= 1'b0;
      rs_from_ram   <= 1'b0;
      byp           <= '0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_len   <= '0;
      mem_abort     <= 1'b0;
      f_buf         <= '0;
      f_waddr       <= '0;
      f_len         <= '0;
      f_keep        <= 1'b0;
      f_cnt         <= '0;
      nx_buf        <= '0;
      nx_waddr      <= '0;
      nx_len        <= '0;
      nx_keep       <= 1'b0;
      tag_base      <= '0;
      tag_cnt       <= '0;
    end else begin
      rs_valid <= 1'b0;
      if (fill_beat) begin
        f_cnt          <= f_cnt + SZW'(1);
        tag_cnt[f_buf] <= f_cnt + SZW'(1);
      end
      if (accept && hit) begin
        rs_valid    <= 1'b1;
        rs_from_ram <= 1'b1;
      end
      if (accept && !hit) begin
        nx_buf   <= sel;
        nx_waddr <= rq_waddr;
        nx_len   <= len_sel;
        nx_keep  <= keep_sel;
      end
      unique case (state)
        ST_IDLE: begin
          if (accept && !hit) state <= ST_LAUNCH;
        end
        ST_LAUNCH: begin
          f_buf             <= nx_buf;
          f_waddr           <= nx_waddr;
          f_len             <= nx_len;
          f_keep            <= nx_keep;
          f_cnt             <= '0;
          tag_base[nx_buf]  <= nx_waddr;
          tag_cnt[nx_buf]   <= '0;
          mem_req_valid     <= 1'b1;
          mem_req_addr      <= {nx_waddr, {BYW{1'b0}}};
          mem_req_len       <= nx_len;
          state             <= ST_REQ;
        end
        ST_REQ: begin
          if (mem_req_ready) begin
            mem_req_valid <= 1'b0;
            state         <= ST_FIRST;
          end
        end
        ST_FIRST: begin
          if (mem_rd_valid) begin
            rs_valid    <= 1'b1;
            rs_from_ram <= 1'b0;
            byp         <= mem_rd_data;
            if (f_keep) begin
              f_cnt          <= SZW'(1);
              tag_cnt[f_buf] <= SZW'(1);
            end
            state <= (f_keep && f_len != SZW'(1)) ? ST_FILL : ST_IDLE;
          end
        end
        ST_FILL: begin
          if (accept && !hit && sel == f_buf) begin
            mem_abort <= 1'b1;
            state     <= ST_ABORT;
          end else if (accept && !hit) begin
            state <= last_beat ? ST_LAUNCH : ST_WAITF;
          end else if (last_beat) begin
            state <= ST_IDLE;
          end
        end
        ST_WAITF: begin
          if (last_beat) state <= ST_LAUNCH;
        end
        ST_ABORT: begin
          if (mem_abort_ack) begin
            mem_abort <= 1'b0;
            state     <= ST_LAUNCH;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  assert_req_stable_R13: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_len));

  assert_req_shape_R4: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_addr[BYW-1:0] == '0) && (mem_req_len != '0)
                      && (mem_req_len <= SZW'(DEPTH)));

  assert_no_req_in_abort_R8: assert property (@(posedge clk) disable iff (rst)
    mem_abort |-> !mem_req_valid);

  assert_abort_held_R8: assert property (@(posedge clk) disable iff (rst)
    mem_abort && !mem_abort_ack |=> mem_abort);

  assert_hit_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) && accept && hit |=> rs_valid && !mem_req_valid);

  assert_write_in_part_R1: assert property (@(posedge clk) disable iff (rst)
    st_we |-> ((SZW'(st_waddr) - part_base[f_buf]) < eff_size[f_buf]));

  assert_first_word_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FIRST) && mem_rd_valid |=> rs_valid && !rs_from_ram);
endmodule

// File: tb/rd_prefetch_buf_tb.sv
`timescale 1ns/1ps
module rd_prefetch_buf_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic            cfg_pf_en;
  logic [3:0]      cfg_buf_pf_en;
  logic [3:0][7:0] cfg_buf_size;
  logic [3:0][3:0] cfg_buf_mid;
  logic            rq_valid, rq_ready;
  logic [3:0]      rq_mid;
  logic [31:0]     rq_addr;
  logic            rs_valid;
  logic [63:0]     rs_data;
  logic            mem_req_valid, mem_req_ready;
  logic [31:0]     mem_req_addr;
  logic [7:0]      mem_req_len;
  logic            mem_rd_valid;
  logic [63:0]     mem_rd_data;
  logic            mem_abort, mem_abort_ack;

  rd_prefetch_buf u_dut (
    .clk(clk), .rst(rst), .cfg_pf_en(cfg_pf_en), .cfg_buf_pf_en(cfg_buf_pf_en),
    .cfg_buf_size(cfg_buf_size), .cfg_buf_mid(cfg_buf_mid),
    .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_mid(rq_mid), .rq_addr(rq_addr),
    .rs_valid(rs_valid), .rs_data(rs_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_len(mem_req_len),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .mem_abort(mem_abort), .mem_abort_ack(mem_abort_ack));

  int n_chk = 0, n_err = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] mdat(input logic [28:0] w);
    return {~{3'b0, w}, {3'b0, w}};
  endfunction

  // ---------------- memory engine model ----------------
  int e_st = 0, e_idx = 0, e_len = 0, e_gap_cnt = 0, e_rdy_wait = 0;
  int eng_gap = 0, eng_rdy_dly = 2;
  logic [28:0] e_waddr;
  logic [31:0] e_addr, prev_addr;
  logic [7:0]  prev_len;
  logic        prev_valid = 1'b0;
  int n_req = 0, n_abort = 0, stab_err = 0, ovl_err = 0, fb_cyc = 0;

  always @(negedge clk) begin
    if (rst) begin
      mem_req_ready = 1'b0; mem_rd_valid = 1'b0; mem_rd_data = '0;
      mem_abort_ack = 1'b0; e_st = 0; prev_valid = 1'b0;
    end else begin
      mem_req_ready = 1'b0; mem_rd_valid = 1'b0; mem_abort_ack = 1'b0;
      if (mem_req_valid && e_st != 0) ovl_err++;
      if (mem_req_valid && prev_valid &&
          (mem_req_addr != prev_addr || mem_req_len != prev_len)) stab_err++;
      prev_valid = mem_req_valid; prev_addr = mem_req_addr; prev_len = mem_req_len;
      if (mem_abort) begin
        mem_abort_ack = 1'b1; e_st = 0; n_abort++;
      end else if (e_st == 0 && mem_req_valid) begin
        if (e_rdy_wait < eng_rdy_dly) e_rdy_wait++;
        else begin
          mem_req_ready = 1'b1; e_addr = mem_req_addr; e_waddr = mem_req_addr[31:3];
          e_len = int'(mem_req_len); e_st = 1; e_idx = 0; e_gap_cnt = 0;
          e_rdy_wait = 0; n_req++; prev_valid = 1'b0;
        end
      end else if (e_st == 1) begin
        if (e_gap_cnt < eng_gap) e_gap_cnt++;
        else begin
          e_gap_cnt = 0; mem_rd_valid = 1'b1;
          mem_rd_data = mdat(e_waddr + 29'(e_idx));
          if (e_idx == 0) fb_cyc = cyc;
          e_idx++;
          if (e_idx == e_len) e_st = 0;
        end
      end
    end
  end

  // ---------------- response monitor ----------------
  int rs_cnt = 0, rs_cyc = 0;
  logic [63:0] rs_last;
  always @(negedge clk) if (!rst && rs_valid) begin
    rs_cnt++; rs_last = rs_data; rs_cyc = cyc;
  end

  // ---------------- helpers ----------------
  task automatic tick(); @(negedge clk); #1; endtask

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] mid, input logic [31:0] addr);
    int w = 0;
    while (!rq_ready && w < 2000) begin tick(); w++; end
    rq_valid = 1'b1; rq_mid = mid; rq_addr = addr;
    tick();
    rq_valid = 1'b0;
  endtask

  task automatic wait_resp(input int r0);
    int w = 0;
    while (rs_cnt == r0 && w < 2000) begin tick(); w++; end
  endtask

  task automatic wait_quiet();
    int w = 0;
    tick();
    while (!(e_st == 0 && !mem_req_valid && !mem_abort && rq_ready) && w < 4000) begin
      tick(); w++;
    end
    tick(); tick();
  endtask

  task automatic expect_miss(input logic [3:0] mid, input logic [31:0] addr,
                             input int exp_len, input string rq);
    int n0 = n_req, r0 = rs_cnt;
    issue(mid, addr);
    wait_resp(r0);
    chk(rs_cnt == r0 + 1, rq, 64'(rs_cnt), 64'(r0 + 1));
    chk(rs_last == mdat(addr[31:3]), rq, rs_last, mdat(addr[31:3]));
    chk(n_req == n0 + 1, rq, 64'(n_req), 64'(n0 + 1));
    chk(e_addr == {addr[31:3], 3'b0}, rq, 64'(e_addr), 64'({addr[31:3], 3'b0}));
    chk(e_len == exp_len, rq, 64'(e_len), 64'(exp_len));
  endtask

  task automatic expect_hit(input logic [3:0] mid, input logic [31:0] addr, input string rq);
    int n0 = n_req, r0 = rs_cnt;
    issue(mid, addr);
    chk(rs_cnt == r0 + 1, rq, 64'(rs_cnt), 64'(r0 + 1));
    chk(rs_last == mdat(addr[31:3]), rq, rs_last, mdat(addr[31:3]));
    chk(n_req == n0, rq, 64'(n_req), 64'(n0));
  endtask

  task automatic set_sizes(input int s0, input int s1, input int s2, input int s3);
    cfg_buf_size[0] = 8'(s0); cfg_buf_size[1] = 8'(s1);
    cfg_buf_size[2] = 8'(s2); cfg_buf_size[3] = 8'(s3);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(rs_valid == 1'b0, "R12 in reset", 64'(rs_valid), 0);
    rst = 1'b0;
    tick(); tick();
    chk(rq_ready == 1'b1, "R12 ready", 64'(rq_ready), 1);
    chk(rs_valid == 1'b0, "R12 rs_valid", 64'(rs_valid), 0);
    chk(mem_req_valid == 1'b0, "R12 mem_req_valid", 64'(mem_req_valid), 0);
    chk(mem_abort == 1'b0, "R12 mem_abort", 64'(mem_abort), 0);
  endtask

  task automatic t_miss_and_hits();
    expect_miss(4'd1, 32'h1004, 16, "R4 miss fill");
    chk(rs_cyc == fb_cyc + 1, "R5 first word timing", 64'(rs_cyc), 64'(fb_cyc + 1));
    chk(stab_err == 0, "R13 request held stable", 64'(stab_err), 0);
    wait_quiet();
    expect_hit(4'd1, 32'h1038, "R6 hit middle");
    expect_hit(4'd1, 32'h1000, "R6 hit first word");
    expect_hit(4'd1, 32'h1078, "R6 hit last word");
    wait_quiet();
    expect_miss(4'd1, 32'h1080, 16, "R6 one past end misses");
    wait_quiet();
  endtask

  task automatic t_master_map();
    expect_miss(4'd9, 32'h8000, 16, "R2 unmatched id to shared");
    wait_quiet();
    expect_miss(4'd3, 32'h8008, 16, "R2 own partition separate");
    wait_quiet();
    expect_hit(4'd7, 32'h8010, "R2 other unmatched id shares");
    expect_hit(4'd15, 32'h8018, "R1 R2 shared data intact");
    expect_hit(4'd3, 32'h8010, "R1 partition 2 data intact");
  endtask

  task automatic t_disabled();
    cfg_pf_en = 1'b0;
    expect_miss(4'd9, 32'h8010, 1, "R3 global off single word");
    wait_quiet();
    expect_miss(4'd9, 32'h8010, 1, "R7 repeat not kept");
    wait_quiet();
    cfg_pf_en = 1'b1; cfg_buf_pf_en[3] = 1'b0;
    expect_miss(4'd9, 32'h8010, 1, "R3 partition enable off");
    wait_quiet();
    cfg_buf_pf_en[3] = 1'b1;
    expect_miss(4'd9, 32'h8010, 16, "R3 both enables on");
    wait_quiet();
  endtask

  task automatic t_clamp();
    set_sizes(100, 50, 20, 20);
    tick();
    expect_miss(4'd2, 32'hA000, 28, "R10 clamp to remaining room");
    wait_quiet();
    expect_hit(4'd2, 32'hA0D8, "R10 last clamped word hits");
    expect_miss(4'd3, 32'hB000, 1, "R10 zero room gives single word");
    wait_quiet();
    expect_miss(4'd15, 32'hC000, 1, "R10 zero room shared");
    wait_quiet();
    set_sizes(16, 16, 16, 16);
    tick();
  endtask

  task automatic t_abort();
    int n0, a0, r0;
    eng_gap = 3;
    expect_miss(4'd1, 32'h2000, 16, "R4 slow fill");
    repeat (12) tick();
    expect_hit(4'd1, 32'h2008, "R11 hit on arrived word mid-fill");
    n0 = n_req; a0 = n_abort; r0 = rs_cnt;
    issue(4'd1, 32'h3000);
    wait_resp(r0);
    chk(n_abort == a0 + 1, "R8 abort raised once", 64'(n_abort), 64'(a0 + 1));
    chk(n_req == n0 + 1, "R8 one new request", 64'(n_req), 64'(n0 + 1));
    chk(e_addr == 32'h3000, "R8 new burst address", 64'(e_addr), 64'h3000);
    chk(rs_last == mdat(29'h600), "R8 new data", rs_last, mdat(29'h600));
    chk(ovl_err == 0, "R8 no request during burst", 64'(ovl_err), 0);
    wait_quiet();
    expect_hit(4'd1, 32'h3040, "R11 refilled after abort");
    eng_gap = 0;
    expect_miss(4'd1, 32'h2010, 16, "R8 old contents discarded");
    wait_quiet();
  endtask

  task automatic t_wait_other();
    int a0, r0;
    eng_gap = 3;
    expect_miss(4'd1, 32'h4000, 16, "R4 fill before wait");
    repeat (3) tick();
    a0 = n_abort; r0 = rs_cnt;
    issue(4'd2, 32'h5000);
    wait_resp(r0);
    chk(n_abort == a0, "R9 no abort for other master", 64'(n_abort), 64'(a0));
    chk(ovl_err == 0, "R9 waited for burst end", 64'(ovl_err), 0);
    chk(e_addr == 32'h5000, "R9 queued address", 64'(e_addr), 64'h5000);
    chk(rs_last == mdat(29'hA00), "R9 queued data", rs_last, mdat(29'hA00));
    wait_quiet();
    expect_hit(4'd1, 32'h4078, "R9 first burst completed");
    eng_gap = 0;
  endtask

  // ---------------- main and watchdog ----------------
  bit finished = 1'b0;

  initial begin
    cfg_pf_en = 1'b1; cfg_buf_pf_en = 4'hF;
    set_sizes(16, 16, 16, 16);
    cfg_buf_mid[0] = 4'd1; cfg_buf_mid[1] = 4'd2;
    cfg_buf_mid[2] = 4'd3; cfg_buf_mid[3] = 4'd15;
    rq_valid = 1'b0; rq_mid = '0; rq_addr = '0;
    repeat (4) tick();
    t_reset();
    t_miss_and_hits();
    t_master_map();
    t_disabled();
    t_clamp();
    t_abort();
    t_wait_other();
    chk(stab_err == 0, "R13 final stability", 64'(stab_err), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog all actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule